// File: doc/BRIEF.md
# Trap and Privilege Stack Controller

This block owns the processor status word and the two stack pointers, one for user code and one for the supervisor. It also runs the memory sequences that enter and leave a software trap. The instruction decoder sends it one-cycle operation strobes, together with the immediate field, the source register value and the current program counter. The controller drives one single-word stack port, which either writes or reads in a given cycle, and it returns a program-counter load, the status word, the stack pointer that software sees, read-back data, a privilege-fault pulse and a busy flag. The busy flag holds the rest of the pipeline while a sequence is running.

Trap entry and trap return always use the supervisor stack, whatever the current mode. Each of them takes three busy cycles. A stop operation sets the stop bit, and after that the controller does nothing more until reset. The data width is a parameter and defaults to 16 bits.

Top module: `trap_priv_ctrl`

## Requirements
- R1: Reset leaves the status word at zero, so the user bit (bit 0) and the stop bit (bit 1) are both clear and the controller is in supervisor mode. Both stack pointers are zero, and busy, fault, read-valid, stack-write, stack-read and PC-load outputs are all low.
- R2: A trap strobe (`swi_i`) starts a sequence with two stack writes on consecutive cycles. The first write stores the captured PC at supervisor SP minus 1. The second stores the status word as it was before the trap, at supervisor SP minus 2. This holds even when the trap is taken from user mode.
- R3: In the third cycle of the trap sequence, `pc_load_o` is high and `pc_o` carries the trap immediate. The user bit is already clear in that cycle. `busy_o` stays high for exactly three cycles.
- R4: A return strobe (`rti_i`) reads the status word from supervisor SP and then reads the PC from supervisor SP plus 1. The supervisor SP ends up 2 higher than before. In the third cycle, `pc_o` carries the PC that was read and `pc_load_o` is high.
- R5: `sp_o` shows the user stack pointer while the user bit is set, and the supervisor stack pointer otherwise.
- R6: A load-SP strobe writes the immediate shifted left by 8 into the stack pointer of the current mode. The new value is visible on `sp_o` one cycle later.
- R7: In supervisor mode, a status-read strobe or a user-SP-read strobe returns the value on `rd_data_o`, with `rd_valid_o` high, in the next cycle. A status-write strobe copies `reg_wdata_i` into the status word.
- R8: In user mode, a status read, a status write or a user-SP read raises `fault_o` for exactly one cycle. It produces no read-back and changes neither the status word nor any stack pointer.
- R9: A stop strobe sets the stop bit (bit 1) and clears nothing else. From then on, `busy_o` stays high and every strobe is ignored until reset.
- R10: Strobes that arrive while a trap or return sequence is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| swi_i | input | 1 | Software trap strobe |
| rti_i | input | 1 | Return-from-trap strobe |
| stop_i | input | 1 | Stop strobe |
| lsp_i | input | 1 | Load the active SP from the immediate |
| gsr_i | input | 1 | Read the status word (privileged) |
| ssr_i | input | 1 | Write the status word (privileged) |
| gusp_i | input | 1 | Read the user SP (privileged) |
| imm_i | input | DW | Immediate field: the trap vector or the SP load value |
| reg_wdata_i | input | DW | Source register value used by a status write |
| pc_i | input | DW | Current program counter, captured by a trap |
| mem_we_o | output | 1 | Stack write strobe |
| mem_re_o | output | 1 | Stack read strobe |
| mem_addr_o | output | DW | Stack word address |
| mem_wdata_o | output | DW | Stack write data |
| mem_rdata_i | input | DW | Stack read data, valid in the same cycle as the address |
| pc_load_o | output | 1 | Load the PC from `pc_o` |
| pc_o | output | DW | New program counter |
| sr_o | output | DW | Status word |
| sp_o | output | DW | Stack pointer of the current mode |
| rd_valid_o | output | 1 | Read-back data is valid |
| rd_data_o | output | DW | Read-back data |
| fault_o | output | 1 | Privilege fault pulse |
| busy_o | output | 1 | Sequence running or halted, so the pipeline must stall |

## Verification
The hardest state to reach is a non-zero user stack pointer that is then read back. That pointer can only be loaded while the controller is in user mode, and it can only be read while the controller is in supervisor mode. The stimulus therefore writes the status word to enter user mode and loads the user SP there. It confirms that privileged reads now fault, and then takes a software trap to return to supervisor mode, where the user SP read must return the value loaded earlier. A return then pops the pushed status word, which puts the controller back in user mode on the user stack. While the trap is still running, a load-SP strobe is issued, and it must leave no trace.

// File: rtl/trap_priv_pkg.sv
package trap_priv_pkg;

  typedef enum logic [2:0] {
    TS_IDLE,
    TS_PUSH_PC,
    TS_PUSH_SR,
    TS_VECTOR,
    TS_POP_SR,
    TS_POP_PC,
    TS_RETURN,
    TS_HALT
  } tps_state_e;

endpackage

// File: rtl/tpc_seq.sv
module tpc_seq
  import trap_priv_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          swi_go,
  input  logic          rti_go,
  input  logic          stop_go,
  input  logic [DW-1:0] imm_i,
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] mem_rdata_i,
  output tps_state_e    state_o,
  output logic [DW-1:0] saved_pc_o,
  output logic [DW-1:0] target_o
);

  tps_state_e    state_q, state_d;
  logic [DW-1:0] saved_pc_q, target_q, target_d;
  logic          target_en;

  always_comb begin
    state_d   = state_q;
    target_d  = target_q;
    target_en = 1'b0;
    unique case (state_q)
      TS_IDLE: begin
        if (swi_go) begin
          state_d   = TS_PUSH_PC;
          target_d  = imm_i;
          target_en = 1'b1;
        end else if (rti_go) begin
          state_d = TS_POP_SR;
        end else if (stop_go) begin
          state_d = TS_HALT;
        end
      end
      TS_PUSH_PC: state_d = TS_PUSH_SR;
      TS_PUSH_SR: state_d = TS_VECTOR;
      TS_VECTOR:  state_d = TS_IDLE;
      TS_POP_SR:  state_d = TS_POP_PC;
      TS_POP_PC: begin
        state_d   = TS_RETURN;
        target_d  = mem_rdata_i;
        target_en = 1'b1;
      end
      TS_RETURN:  state_d = TS_IDLE;
      TS_HALT:    state_d = TS_HALT;
      default:    state_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= TS_IDLE;
      saved_pc_q <= '0;
      target_q   <= '0;
    end else begin
      state_q <= state_d;
      if (swi_go)    saved_pc_q <= pc_i;
      if (target_en) target_q   <= target_d;
    end
  end

  assign state_o    = state_q;
  assign saved_pc_o = saved_pc_q;
  assign target_o   = target_q;

endmodule

// File: rtl/tpc_stack_ptrs.sv
module tpc_stack_ptrs #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          user_mode,
  input  logic          ssp_dec,
  input  logic          ssp_inc,
  input  logic          sp_load,
  input  logic [DW-1:0] sp_val,
  output logic [DW-1:0] usp_o,
  output logic [DW-1:0] ssp_o,
  output logic [DW-1:0] sp_o
);

  logic [DW-1:0] usp_q, ssp_q, usp_d, ssp_d;
  logic          usp_en, ssp_en;

  always_comb begin
    usp_d  = usp_q;
    ssp_d  = ssp_q;
    usp_en = 1'b0;
    ssp_en = 1'b0;
    if (ssp_dec) begin
      ssp_d  = ssp_q - DW'(1);
      ssp_en = 1'b1;
    end else if (ssp_inc) begin
      ssp_d  = ssp_q + DW'(1);
      ssp_en = 1'b1;
    end else if (sp_load) begin
      if (user_mode) begin
        usp_d  = sp_val;
        usp_en = 1'b1;
      end else begin
        ssp_d  = sp_val;
        ssp_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usp_q <= '0;
      ssp_q <= '0;
    end else begin
      if (usp_en) usp_q <= usp_d;
      if (ssp_en) ssp_q <= ssp_d;
    end
  end

  assign usp_o = usp_q;
  assign ssp_o = ssp_q;
  assign sp_o  = user_mode ? usp_q : ssp_q;

endmodule

// File: rtl/tpc_status.sv
module tpc_status #(
  parameter int DW       = 16,
  parameter int USER_BIT = 0,
  parameter int STOP_BIT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sr_wr,
  input  logic [DW-1:0] sr_wr_val,
  input  logic          clr_user,
  input  logic          set_stop,
  output logic [DW-1:0] sr_o
);

  logic [DW-1:0] sr_q, sr_d;
  logic          sr_en;

  always_comb begin
    sr_d  = sr_q;
    sr_en = 1'b0;
    if (set_stop) begin
      sr_d[STOP_BIT] = 1'b1;
      sr_en          = 1'b1;
    end else if (sr_wr) begin
      sr_d  = sr_wr_val;
      sr_en = 1'b1;
    end else if (clr_user) begin
      sr_d[USER_BIT] = 1'b0;
      sr_en          = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  assign sr_o = sr_q;

endmodule

// File: rtl/trap_priv_ctrl.sv
module trap_priv_ctrl
  import trap_priv_pkg::*;
#(
  parameter int DW        = 16,
  parameter int USER_BIT  = 0,
  parameter int STOP_BIT  = 1,
  parameter int LSP_SHIFT = 8,
  parameter int RST_SYNC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          swi_i,
  input  logic          rti_i,
  input  logic          stop_i,
  input  logic          lsp_i,
  input  logic          gsr_i,
  input  logic          ssr_i,
  input  logic          gusp_i,
  input  logic [DW-1:0] imm_i,
  input  logic [DW-1:0] reg_wdata_i,
  input  logic [DW-1:0] pc_i,
  output logic          mem_we_o,
  output logic          mem_re_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          pc_load_o,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] sr_o,
  output logic [DW-1:0] sp_o,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic          fault_o,
  output logic          busy_o
);

  // reset: asserted asynchronously, released through a flop chain
  logic [RST_SYNC-1:0] rst_chain_q;
  logic                rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_chain_q <= '0;
    else        rst_chain_q <= {rst_chain_q[RST_SYNC-2:0], 1'b1};
  end
  assign rst_int_n = rst_chain_q[RST_SYNC-1];

  tps_state_e    state;
  logic [DW-1:0] saved_pc, target, usp, ssp, sr;
  logic          idle, user_mode;
  logic          swi_go, rti_go, stop_go, lsp_go, gsr_go, ssr_go, gusp_go;
  logic          priv_fault, push_cyc, pop_cyc;
  logic          rd_valid_q, fault_q;
  logic [DW-1:0] rd_data_q, rd_data_d;

  assign idle      = (state == TS_IDLE);
  assign user_mode = sr[USER_BIT];

  // one operation per cycle; priority trap > return > stop > load-SP > reads/writes
  always_comb begin
    swi_go     = 1'b0;
    rti_go     = 1'b0;
    stop_go    = 1'b0;
    lsp_go     = 1'b0;
    gsr_go     = 1'b0;
    ssr_go     = 1'b0;
    gusp_go    = 1'b0;
    priv_fault = 1'b0;
    if (idle) begin
      if (swi_i)       swi_go  = 1'b1;
      else if (rti_i)  rti_go  = 1'b1;
      else if (stop_i) stop_go = 1'b1;
      else if (lsp_i)  lsp_go  = 1'b1;
      else if (gsr_i || ssr_i || gusp_i) begin
        if (user_mode) priv_fault = 1'b1;
        else if (gsr_i) gsr_go = 1'b1;
        else if (ssr_i) ssr_go = 1'b1;
        else            gusp_go = 1'b1;
      end
    end
  end

  assign push_cyc = (state == TS_PUSH_PC) || (state == TS_PUSH_SR);
  assign pop_cyc  = (state == TS_POP_SR)  || (state == TS_POP_PC);

  tpc_seq #(.DW(DW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .swi_go      (swi_go),
    .rti_go      (rti_go),
    .stop_go     (stop_go),
    .imm_i       (imm_i),
    .pc_i        (pc_i),
    .mem_rdata_i (mem_rdata_i),
    .state_o     (state),
    .saved_pc_o  (saved_pc),
    .target_o    (target)
  );

  tpc_stack_ptrs #(.DW(DW)) u_sp (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .user_mode (user_mode),
    .ssp_dec   (push_cyc),
    .ssp_inc   (pop_cyc),
    .sp_load   (lsp_go),
    .sp_val    (imm_i << LSP_SHIFT),
    .usp_o     (usp),
    .ssp_o     (ssp),
    .sp_o      (sp_o)
  );

  tpc_status #(.DW(DW), .USER_BIT(USER_BIT), .STOP_BIT(STOP_BIT)) u_sr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sr_wr     (ssr_go || (state == TS_POP_SR)),
    .sr_wr_val ((state == TS_POP_SR) ? mem_rdata_i : reg_wdata_i),
    .clr_user  (state == TS_PUSH_SR),
    .set_stop  (stop_go),
    .sr_o      (sr)
  );

  assign rd_data_d = gsr_go ? sr : usp;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      fault_q    <= 1'b0;
    end else begin
      rd_valid_q <= gsr_go || gusp_go;
      fault_q    <= priv_fault;
      if (gsr_go || gusp_go) rd_data_q <= rd_data_d;
    end
  end

  assign mem_we_o    = push_cyc;
  assign mem_re_o    = pop_cyc;
  assign mem_addr_o  = push_cyc ? (ssp - DW'(1)) : ssp;
  assign mem_wdata_o = (state == TS_PUSH_PC) ? saved_pc : sr;
  assign pc_load_o   = (state == TS_VECTOR) || (state == TS_RETURN);
  assign pc_o        = target;
  assign sr_o        = sr;
  assign rd_valid_o  = rd_valid_q;
  assign rd_data_o   = rd_data_q;
  assign fault_o     = fault_q;
  assign busy_o      = !idle;

endmodule

// File: rtl/trap_priv_ctrl_chk.sv
module trap_priv_ctrl_chk #(
  parameter int DW       = 16,
  parameter int USER_BIT = 0,
  parameter int STOP_BIT = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_we_o,
  input logic          mem_re_o,
  input logic [DW-1:0] mem_addr_o,
  input logic          pc_load_o,
  input logic          fault_o,
  input logic          busy_o,
  input logic          rd_valid_o,
  input logic [DW-1:0] sr_o,
  input logic [DW-1:0] sp_o
);

  // R2
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o));

  // R2
  push_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && !$past(mem_we_o)) |=> (mem_we_o && mem_addr_o == $past(mem_addr_o) - DW'(1)));

  // R3
  vector_super_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load_o && $past(mem_we_o)) |-> !sr_o[USER_BIT]);

  // R4
  pop_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re_o && $past(mem_re_o)) |-> mem_addr_o == $past(mem_addr_o) + DW'(1));

  // R8
  fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> !fault_o);

  // R8
  fault_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> ($stable(sr_o) && $stable(sp_o) && !rd_valid_o));

  // R9
  stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_o[STOP_BIT] |=> (sr_o[STOP_BIT] && busy_o));

  // R9
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_o[STOP_BIT] |-> !(mem_we_o || mem_re_o || pc_load_o));

endmodule

bind trap_priv_ctrl trap_priv_ctrl_chk #(.DW(DW), .USER_BIT(USER_BIT), .STOP_BIT(STOP_BIT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_we_o   (mem_we_o),
  .mem_re_o   (mem_re_o),
  .mem_addr_o (mem_addr_o),
  .pc_load_o  (pc_load_o),
  .fault_o    (fault_o),
  .busy_o     (busy_o),
  .rd_valid_o (rd_valid_o),
  .sr_o       (sr_o),
  .sp_o       (sp_o)
);

// File: tb/tb_trap_priv_ctrl.sv
module tb_trap_priv_ctrl;

  localparam int DW     = 16;
  localparam int CLK_NS = 10;

  localparam int K_WR = 0;
  localparam int K_RD = 1;
  localparam int K_PC = 2;
  localparam int K_FT = 3;
  localparam int K_RV = 4;

  typedef struct {
    int          kind;
    int          req;
    logic [15:0] a;
    logic [15:0] d;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic swi, rti, stp, lsp, gsr, ssr, gusp;
  logic [DW-1:0] imm, wdat, pc;
  logic mem_we, mem_re, pc_load, rd_valid, fault, busy;
  logic [DW-1:0] mem_addr, mem_wdata, mem_rdata, pc_o, sr_o, sp_o, rd_data;
  logic [DW-1:0] mem [0:255];

  int checks = 0, failures = 0, busy_cnt = 0, cyc = 0;
  bit done = 1'b0;
  exp_t expq[$];

  always #(CLK_NS/2) clk = ~clk;

  trap_priv_ctrl dut (
    .clk(clk), .rst_n(rst_n), .swi_i(swi), .rti_i(rti), .stop_i(stp), .lsp_i(lsp),
    .gsr_i(gsr), .ssr_i(ssr), .gusp_i(gusp), .imm_i(imm), .reg_wdata_i(wdat), .pc_i(pc),
    .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .pc_load_o(pc_load), .pc_o(pc_o), .sr_o(sr_o), .sp_o(sp_o),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .fault_o(fault), .busy_o(busy)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_ev(input int kind, input int req, input logic [15:0] a, input logic [15:0] d);
    exp_t e;
    e.kind = kind; e.req = req; e.a = a; e.d = d;
    expq.push_back(e);
  endtask

  // monitor: pops one expected item for each event the design shows
  task automatic take(input int kind, input logic [15:0] a, input logic [15:0] d);
    exp_t e;
    checks++;
    if (expq.size() == 0) begin
      failures++;
      $display("FAIL unexpected event kind=%0d actual=%h/%h expected=none", kind, a, d);
    end else begin
      e = expq.pop_front();
      if (e.kind != kind || e.a !== a || e.d !== d) begin
        failures++;
        $display("FAIL R%0d actual=%0d:%h/%h expected=%0d:%h/%h", e.req, kind, a, d, e.kind, e.a, e.d);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we)   take(K_WR, mem_addr, mem_wdata);
      if (mem_re)   take(K_RD, mem_addr, 16'h0);
      if (pc_load)  take(K_PC, 16'h0, pc_o);
      if (fault)    take(K_FT, 16'h0, 16'h0);
      if (rd_valid) take(K_RV, 16'h0, rd_data);
      if (busy) busy_cnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic op(input int which, input logic [15:0] i, input logic [15:0] w, input logic [15:0] p);
    imm = i; wdat = w; pc = p;
    case (which)
      0: swi = 1'b1;
      1: rti = 1'b1;
      2: stp = 1'b1;
      3: lsp = 1'b1;
      4: gsr = 1'b1;
      5: ssr = 1'b1;
      default: gusp = 1'b1;
    endcase
    @(negedge clk);
    {swi, rti, stp, lsp, gsr, ssr, gusp} = '0;
  endtask

  task automatic idle_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = '0;
    {swi, rti, stp, lsp, gsr, ssr, gusp} = '0;
    imm = '0; wdat = '0; pc = '0;
    rst_n = 1'b0;
    idle_n(3);
    rst_n = 1'b1;
    idle_n(4);

    // R1 reset state
    chk("R1 sr", sr_o, 16'h0000);
    chk("R1 sp", sp_o, 16'h0000);
    chk("R1 strobes", {11'd0, busy, fault, rd_valid, mem_we, pc_load}, 16'h0);

    // R6 load supervisor SP
    op(3, 16'h0012, 0, 0); idle_n(1);
    chk("R6 ssp load", sp_o, 16'h1200);

    // R7 status read in supervisor mode
    expect_ev(K_RV, 7, 16'h0, 16'h0000);
    op(4, 0, 0, 0); idle_n(2);

    // R7 status write -> user mode; R5 view switches to user SP
    op(5, 0, 16'h0001, 0); idle_n(1);
    chk("R7 sr write", sr_o, 16'h0001);
    chk("R5 usp shown", sp_o, 16'h0000);

    // R6 load in user mode targets the user SP
    op(3, 16'h0034, 0, 0); idle_n(1);
    chk("R6 usp load", sp_o, 16'h3400);

    // R8 privileged ops fault in user mode
    expect_ev(K_FT, 8, 0, 0);
    op(4, 0, 0, 0); idle_n(1);
    expect_ev(K_FT, 8, 0, 0);
    op(5, 0, 16'h0000, 0); idle_n(1);
    expect_ev(K_FT, 8, 0, 0);
    op(6, 0, 0, 0); idle_n(1);
    chk("R8 sr kept", sr_o, 16'h0001);
    chk("R8 sp kept", sp_o, 16'h3400);

    // R2/R3 trap from user mode; R10 load-SP during the sequence is dropped
    expect_ev(K_WR, 2, 16'h11FF, 16'h0456);
    expect_ev(K_WR, 2, 16'h11FE, 16'h0001);
    expect_ev(K_PC, 3, 16'h0, 16'h0080);
    busy_cnt = 0;
    op(0, 16'h0080, 0, 16'h0456);
    op(3, 16'h0077, 0, 0);
    idle_n(4);
    chk("R3 busy cycles", 16'(busy_cnt), 16'd3);
    chk("R3 supervisor", sr_o, 16'h0000);
    chk("R10 sp untouched", sp_o, 16'h11FE);

    // R7 user SP read back from supervisor mode
    expect_ev(K_RV, 7, 16'h0, 16'h3400);
    op(6, 0, 0, 0); idle_n(2);

    // R4 return pops status then PC
    expect_ev(K_RD, 4, 16'h11FE, 16'h0);
    expect_ev(K_RD, 4, 16'h11FF, 16'h0);
    expect_ev(K_PC, 4, 16'h0, 16'h0456);
    op(1, 0, 0, 0); idle_n(4);
    chk("R4 sr restored", sr_o, 16'h0001);
    chk("R5 back on usp", sp_o, 16'h3400);

    // R2 second trap, other vector and PC
    expect_ev(K_WR, 2, 16'h11FF, 16'h0222);
    expect_ev(K_WR, 2, 16'h11FE, 16'h0001);
    expect_ev(K_PC, 3, 16'h0, 16'h0100);
    op(0, 16'h0100, 0, 16'h0222); idle_n(4);
    chk("R4 ssp", sp_o, 16'h11FE);

    // R9 stop then ignored strobes
    op(2, 0, 0, 0); idle_n(1);
    chk("R9 stop bit", sr_o, 16'h0002);
    chk("R9 busy", {15'd0, busy}, 16'h0001);
    op(3, 16'h0055, 0, 0);
    op(0, 16'h0200, 0, 16'h0333);
    op(5, 0, 16'h0001, 0);
    idle_n(5);
    chk("R9 sp frozen", sp_o, 16'h11FE);
    chk("R9 sr frozen", sr_o, 16'h0002);
    chk("R9 busy held", {15'd0, busy}, 16'h0001);

    chk("scoreboard drained", 16'(expq.size()), 16'd0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule